// File: doc/BRIEF.md
# Keyboard Scan-Code Latch for an 8-bit I/O Bus

This block holds the most recent byte delivered by a serial keyboard receiver and raises an interrupt line toward an interrupt controller. The processor fetches the byte from a data port. It then acknowledges by setting and then clearing the top bit of a control port. While that bit is set, the held byte and the interrupt are forced to zero.

Bytes pass through unchanged. Prefix bytes such as 0xF0 receive no special handling, and any conversion between scan-code sets is left to firmware. If a second byte arrives before software has acknowledged the first, the held value becomes an overrun marker and the interrupt stays raised.

The control port can be read and written. A read returns the last value written to it, so software can modify the low seven bits with a read-modify-write sequence. All logic runs on the processor clock. The read and write strobes are treated as single-cycle enables.

Top module: `kbd_scan_latch`

## Requirements
- R1: After a synchronous active-low reset, the held code is 0x00, the interrupt line is low, and the control register reads 0x00.
- R2: A byte strobed in while the interrupt is low and control bit 7 is low is stored unchanged, and the interrupt rises one clock later.
- R3: A byte strobed in while the interrupt is already high and control bit 7 is low replaces the held code with 0xFF, and the interrupt stays high.
- R4: Bytes are stored raw. When 0xF0 is received, acknowledged, and followed by 0x1C, the held code reads 0x1C and not 0x9C.
- R5: While the read strobe is high with address 0x0060, the read data equals the held code. In every other case (strobe low, or an address that is neither port) the read data is 0x00.
- R6: A write to address 0x0061 stores all eight data bits in the control register one clock later, and a read of 0x0061 returns that value.
- R7: While control bit 7 is high, the held code is 0x00 and the interrupt is low from the clock after the bit was registered.
- R8: A byte strobed in while control bit 7 is high is discarded and leaves no code behind after bit 7 is cleared.
- R9: The interrupt is a level. It stays high across reads of the data port and idle cycles until control bit 7 clears it.
- R10: Writes to any address other than 0x0061 change neither the control register nor the held code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a keyboard byte is present |
| rx_byte | input | 8 | Received keyboard byte |
| io_rd | input | 1 | I/O read enable, one cycle |
| io_wr | input | 1 | I/O write enable, one cycle |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| kbd_irq | output | 1 | Keyboard interrupt request level |

## Verification
The embedded assertions check the cycle-level rules on every clock:
- the interrupt rises after an accepted byte;
- an overrun produces 0xFF;
- the latch is forced to zero while the clear bit is set;
- the interrupt holds until it is cleared;
- the control register follows writes and otherwise stays stable;
- the read data is zero when no read is in progress.

Only the bench scenarios can show the complete software sequences. These are the raw handling of a 0xF0 prefix across an acknowledge, the read-modify-write of the low control bits, the discard of bytes that arrive during the clear window, and the absence of any effect from writes to other addresses.

// File: rtl/kbd_scan_pkg.sv
// Package: kbd_scan_pkg
// Holds the shared widths and defaults of the keyboard scan-code latch.
// Assumes an 8-bit data path and a 16-bit I/O address space.
package kbd_scan_pkg;
    localparam int KBD_ADDR_W   = 16;
    localparam int KBD_CODE_W   = 8;
    localparam logic [KBD_ADDR_W-1:0] KBD_DATA_PORT = 16'h0060;
    localparam logic [KBD_ADDR_W-1:0] KBD_CTRL_PORT = 16'h0061;
    localparam logic [KBD_CODE_W-1:0] KBD_OVERRUN   = 8'hFF;
endpackage

// File: rtl/kbd_port_decode.sv
// Module: kbd_port_decode
// Decodes the I/O address into data-port and control-port selects.
// Produces the control write enable and the combinational read-data mux.
// Assumes io_rd and io_wr are single-cycle enables sampled on clk.
module kbd_port_decode #(
    parameter int ADDR_W = 16,
    parameter int CODE_W = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CTRL_PORT = 16'h0061
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [CODE_W-1:0] code_q,
    input  logic [CODE_W-1:0] ctrl_q,
    output logic              ctrl_we,
    output logic [CODE_W-1:0] io_rdata
);
    logic sel_data;
    logic sel_ctrl;

    // Compare the address against the two port numbers.
    always_comb begin
        sel_data = (io_addr == DATA_PORT);
        sel_ctrl = (io_addr == CTRL_PORT);
    end

    // Only a write to the control port produces a register enable.
    always_comb begin
        ctrl_we = io_wr && sel_ctrl;
    end

    // Read-data mux; zero whenever no port is being read.
    always_comb begin
        io_rdata = '0;
        if (io_rd && sel_data) begin
            io_rdata = code_q;
        end else if (io_rd && sel_ctrl) begin
            io_rdata = ctrl_q;
        end
    end

    // R5: no read strobe means zero read data
    assert_rdata_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0));

    // R5: a data-port read returns the held code
    assert_rdata_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == DATA_PORT) |-> (io_rdata == code_q));
endmodule

// File: rtl/kbd_ctrl_reg.sv
// Module: kbd_ctrl_reg
// The 8-bit read/write control register. Its top bit is the latch clear.
// Assumes ctrl_we is already qualified by the port decode.
module kbd_ctrl_reg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] ctrl_q,
    output logic              clr
);
    localparam int CLR_BIT = CODE_W - 1;

    // Hold the last written control value; reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= wdata;
        end
    end

    // Expose the clear bit to the code latch.
    always_comb begin
        clr = ctrl_q[CLR_BIT];
    end

    // R6: a control write lands on the next clock
    assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_q == $past(wdata)));

    // R10: without a control write the register keeps its value
    assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: rtl/kbd_code_latch.sv
// Module: kbd_code_latch
// Holds the received byte and the interrupt level.
// On overrun the held code becomes the overrun marker.
// While clr is high, both the code and the interrupt are forced to zero and
// incoming bytes are dropped.
// Assumes rx_valid is a single-cycle strobe synchronous to clk.
module kbd_code_latch #(
    parameter int CODE_W = 8,
    parameter logic [CODE_W-1:0] OVERRUN = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CODE_W-1:0] rx_byte,
    input  logic              clr,
    output logic [CODE_W-1:0] code_q,
    output logic              irq_q
);
    // Update the held code and the interrupt; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code_q <= '0;
            irq_q  <= 1'b0;
        end else if (rx_valid) begin
            code_q <= irq_q ? OVERRUN : rx_byte;
            irq_q  <= 1'b1;
        end
    end

    // R2: an accepted byte raises the interrupt
    assert_irq_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !clr && !irq_q) |=> (irq_q && code_q == $past(rx_byte)));

    // R3: a byte during a pending request yields the overrun marker
    assert_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !clr && irq_q) |=> (irq_q && code_q == OVERRUN));

    // R7 / R8: a set clear bit empties the latch
    assert_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!irq_q && code_q == '0));

    // R9: the interrupt holds until it is cleared
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr) |=> irq_q);
endmodule

// File: rtl/kbd_scan_latch.sv
// Module: kbd_scan_latch (top)
// Keyboard scan-code latch on an 8-bit I/O bus: a data port returns the byte,
// and a control port whose top bit clears the byte and the interrupt.
// Assumes a single clock domain and single-cycle bus strobes.
module kbd_scan_latch
    import kbd_scan_pkg::*;
#(
    parameter int ADDR_W = KBD_ADDR_W,
    parameter int CODE_W = KBD_CODE_W,
    parameter logic [ADDR_W-1:0] DATA_PORT = KBD_DATA_PORT,
    parameter logic [ADDR_W-1:0] CTRL_PORT = KBD_CTRL_PORT,
    parameter logic [CODE_W-1:0] OVERRUN   = KBD_OVERRUN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CODE_W-1:0] rx_byte,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [CODE_W-1:0] io_wdata,
    output logic [CODE_W-1:0] io_rdata,
    output logic              kbd_irq
);
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] ctrl_q;
    logic              ctrl_we;
    logic              clr;
    logic              irq_q;

    kbd_port_decode #(
        .ADDR_W(ADDR_W), .CODE_W(CODE_W),
        .DATA_PORT(DATA_PORT), .CTRL_PORT(CTRL_PORT)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
        .io_addr(io_addr), .code_q(code_q), .ctrl_q(ctrl_q),
        .ctrl_we(ctrl_we), .io_rdata(io_rdata)
    );

    kbd_ctrl_reg #(.CODE_W(CODE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wdata(io_wdata),
        .ctrl_q(ctrl_q), .clr(clr)
    );

    kbd_code_latch #(.CODE_W(CODE_W), .OVERRUN(OVERRUN)) u_latch (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .clr(clr), .code_q(code_q), .irq_q(irq_q)
    );

    // Drive the interrupt output from the latch.
    always_comb begin
        kbd_irq = irq_q;
    end

    // R1: reset leaves the interrupt low on the next clock
    assert_reset_irq_R1: assert property (@(posedge clk)
        !rst_n |=> !kbd_irq);
endmodule

// File: tb/kbd_scan_latch_test.sv
// Directed bench for kbd_scan_latch. Inputs change on falling edges and
// outputs are sampled after falling edges.
module kbd_scan_latch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       kbd_irq;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    kbd_scan_latch uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .kbd_irq(kbd_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // Sets bit 7, waits for the clear, then restores the low bits.
    task automatic ack(input logic [6:0] low);
        io_write(16'h0061, {1'b1, low});
        @(negedge clk);
        io_write(16'h0061, {1'b0, low});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        io_read(16'h0060, d); check("R1 code", d, 8'h00);
        io_read(16'h0061, d); check("R1 ctrl", d, 8'h00);
        check("R1 irq", {7'd0, kbd_irq}, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] d;
        send_byte(8'h1C);
        check("R2 irq", {7'd0, kbd_irq}, 8'h01);
        io_read(16'h0060, d); check("R2/R5 code", d, 8'h1C);
        repeat (3) @(negedge clk);
        check("R9 irq held", {7'd0, kbd_irq}, 8'h01);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        send_byte(8'h32);
        io_read(16'h0060, d); check("R3 code", d, 8'hFF);
        check("R3 irq", {7'd0, kbd_irq}, 8'h01);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        io_write(16'h0061, 8'h80);
        @(negedge clk);
        check("R7 irq", {7'd0, kbd_irq}, 8'h00);
        io_read(16'h0060, d); check("R7 code", d, 8'h00);
        send_byte(8'h44);
        check("R8 irq", {7'd0, kbd_irq}, 8'h00);
        io_read(16'h0061, d); check("R6 ctrl 80", d, 8'h80);
        io_write(16'h0061, 8'h00);
        @(negedge clk);
        io_read(16'h0060, d); check("R8 code", d, 8'h00);
        check("R8 irq after", {7'd0, kbd_irq}, 8'h00);
    endtask

    task automatic t_raw();
        logic [7:0] d;
        send_byte(8'hF0);
        io_read(16'h0060, d); check("R4 prefix", d, 8'hF0);
        ack(7'h00);
        send_byte(8'h1C);
        io_read(16'h0060, d); check("R4 raw", d, 8'h1C);
        ack(7'h00);
    endtask

    task automatic t_rmw();
        logic [7:0] d;
        io_write(16'h0061, 8'h35);
        io_read(16'h0061, d); check("R6 ctrl", d, 8'h35);
        send_byte(8'h2A);
        io_read(16'h0061, d);
        ack(d[6:0]);
        io_read(16'h0061, d); check("R6 low bits kept", d, 8'h35);
        check("R7 irq acked", {7'd0, kbd_irq}, 8'h00);
    endtask

    task automatic t_ignore();
        logic [7:0] d;
        send_byte(8'h5B);
        io_write(16'h0060, 8'h99);
        io_write(16'h0062, 8'h80);
        io_read(16'h0061, d); check("R10 ctrl", d, 8'h35);
        io_read(16'h0060, d); check("R10 code", d, 8'h5B);
        check("R10 irq", {7'd0, kbd_irq}, 8'h01);
        io_read(16'h0062, d); check("R5 other addr", d, 8'h00);
        @(negedge clk);
        io_addr = 16'h0060;
        #1 check("R5 no strobe", io_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_overrun();
        t_clear();
        t_raw();
        t_rmw();
        t_ignore();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule